// File: doc/BRIEF.md
# Iterative CORDIC Sine/Cosine Engine

This block evaluates the cosine or the sine of an angle and scales the result by a modulus. It uses a sequential CORDIC datapath in rotation mode that performs one micro-rotation per clock. A start pulse captures the function select, the precision field, the width select and the two signed arguments. Argument 1 is the angle: a fixed-point value `a` stands for `a·π` radians. Argument 2 is a non-negative modulus below one. The engine multiplies the modulus by the reciprocal of the CORDIC gain before it iterates. Any angle whose magnitude is above one half is first folded by ±π, and the starting vector is negated to compensate.

Each calculation produces two results, `m·cos` and `m·sin`. The function select decides which of the two appears on the primary port. The precision field sets the number of iterations in steps of four, which trades latency against accuracy. The width select chooses 32-bit (q1.31) or 16-bit (q1.15) arguments and results at run time.

When the last iteration completes, the engine raises a one-cycle done pulse. Both result ports then hold their values until the next done pulse. A start pulse that arrives while a calculation is still running is dropped.

Top module: `cordic_sincos`

## Requirements
- R1: With `func_i`=0 (cosine), `res1_o`=m·cos(θ) and `res2_o`=m·sin(θ). With `func_i`=1 (sine), the two results are swapped.
- R2: The iteration count is 4·`prec_i`. `done_o` is sampled high after exactly N+2 rising edges, counting the edge that accepts the start pulse.
- R3: A `prec_i` of 0 behaves as 1, giving 4 iterations. Any count above 24 (`prec_i` ≥ 7) is limited to 24 iterations.
- R4: With `wide_i`=0, both arguments and both results are signed q1.31, θ = arg1·π, and each result lies within 2^(1-N) + 2^-20 of the exact value.
- R5: With `wide_i`=1, only bits [15:0] of each argument are used, as signed q1.15. Each result is rounded to q1.15 in bits [15:0], and bits [31:16] repeat bit 15.
- R6: In 16-bit mode a result never wraps past the positive limit; it saturates at 0x7FFF. A modulus of 0x7FFF at angle 0 gives a primary cosine result of exactly 0x0000_7FFF.
- R7: Angles over the whole range [-1, 1) are accepted, including -1.0 (0x8000_0000) and magnitudes above one half.
- R8: `done_o` is high for a single cycle per calculation.
- R9: A start pulse received while a calculation is running has no effect. The result and the timing of the running calculation are unchanged, and no extra done pulse follows.
- R10: Results stay stable between done pulses. A start pulse in the same cycle as `done_o` is accepted.
- R11: Synchronous active-high `rst` clears `done_o`, `res1_o` and `res2_o` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; captures all operands when idle |
| func_i | input | 1 | 0 = cosine first, 1 = sine first |
| prec_i | input | 4 | Iteration count divided by four |
| wide_i | input | 1 | 0 = q1.31 operands and results, 1 = q1.15 |
| arg1_i | input | 32 | Angle, in units of π |
| arg2_i | input | 32 | Modulus, non-negative |
| done_o | output | 1 | One-cycle completion pulse |
| res1_o | output | 32 | Primary result |
| res2_o | output | 32 | Secondary result |

## Verification
The completion pulse of one calculation can coincide with the acceptance of the next start. The bench provokes this by issuing every calculation at the negative edge where `done_o` of the previous calculation is observed high. It then judges both the new calculation's N+2 latency and the preceding result values. A second collision is a start pulse that lands while iterations are still running. For that case the bench checks that the first operands' results arrive on schedule and that no second done pulse appears afterwards.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

    localparam int DW       = 32;
    localparam int GW       = 2;
    localparam int IW       = DW + GW;
    localparam int HW       = DW / 2;
    localparam int PW       = 4;
    localparam int TBL_LEN  = 24;
    localparam int CNTW     = $clog2(TBL_LEN + 1);

    // reciprocal of the CORDIC gain, q1.31
    localparam logic signed [DW-1:0] KINV = 32'sd1304065748;

    localparam logic signed [IW-1:0] ONE_A  = {{GW{1'b0}}, 1'b1, {(DW-1){1'b0}}};
    localparam logic signed [IW-1:0] HALF_A = {{(GW+1){1'b0}}, 1'b1, {(DW-2){1'b0}}};
    localparam logic signed [IW-1:0] MAX_W  = {{(GW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [IW-1:0] MIN_W  = {{(GW+1){1'b1}}, {(DW-1){1'b0}}};
    localparam logic signed [IW-1:0] MAX_N  = {{(IW-HW+1){1'b0}}, {(HW-1){1'b1}}};
    localparam logic signed [IW-1:0] MIN_N  = {{(IW-HW+1){1'b1}}, {(HW-1){1'b0}}};
    localparam logic signed [IW-1:0] RND_N  = {{(IW-HW){1'b0}}, 1'b1, {(HW-1){1'b0}}};

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} state_e;
    typedef enum logic {FN_COS = 1'b0, FN_SIN = 1'b1} func_e;

    typedef struct packed {
        logic signed [IW-1:0] x;
        logic signed [IW-1:0] y;
        logic signed [IW-1:0] z;
    } vec_t;

    // atan(2^-i) / pi, scaled by 2^31
    function automatic logic [DW-1:0] atan_step(input logic [CNTW-1:0] i);
        case (i)
            5'd0:  return 32'd536870912;
            5'd1:  return 32'd316933406;
            5'd2:  return 32'd167458908;
            5'd3:  return 32'd85004756;
            5'd4:  return 32'd42667330;
            5'd5:  return 32'd21354465;
            5'd6:  return 32'd10679841;
            5'd7:  return 32'd5340245;
            5'd8:  return 32'd2670163;
            5'd9:  return 32'd1335087;
            5'd10: return 32'd667544;
            5'd11: return 32'd333772;
            5'd12: return 32'd166886;
            5'd13: return 32'd83443;
            5'd14: return 32'd41722;
            5'd15: return 32'd20861;
            5'd16: return 32'd10430;
            5'd17: return 32'd5215;
            5'd18: return 32'd2608;
            5'd19: return 32'd1304;
            5'd20: return 32'd652;
            5'd21: return 32'd326;
            5'd22: return 32'd163;
            5'd23: return 32'd81;
            default: return '0;
        endcase
    endfunction

    function automatic logic [CNTW-1:0] iter_total(input logic [PW-1:0] p);
        int n;
        n = (p == '0) ? 1 : int'(p);
        n = n * 4;
        if (n > TBL_LEN) n = TBL_LEN;
        return CNTW'(n);
    endfunction

    function automatic logic [DW-1:0] fmt_out(input logic signed [IW-1:0] v, input logic narrow);
        logic signed [IW-1:0] r;
        if (narrow) begin
            r = (v + RND_N) >>> HW;
            if (r > MAX_N) r = MAX_N;
            else if (r < MIN_N) r = MIN_N;
        end else begin
            r = v;
            if (r > MAX_W) r = MAX_W;
            else if (r < MIN_W) r = MIN_W;
        end
        return r[DW-1:0];
    endfunction

endpackage

// File: rtl/cordic_prep.sv
module cordic_prep
    import cordic_pkg::*;
(
    input  logic          narrow,
    input  logic [DW-1:0] ang_in,
    input  logic [DW-1:0] mod_in,
    output vec_t          v0
);
    logic signed [DW-1:0]   ang, modv;
    logic signed [IW-1:0]   ang_e, xs;
    logic signed [2*DW-1:0] prod;
    logic                   fold;

    always_comb begin
        ang   = narrow ? {ang_in[HW-1:0], {HW{1'b0}}} : ang_in;
        modv  = narrow ? {mod_in[HW-1:0], {HW{1'b0}}} : mod_in;
        ang_e = IW'(ang);
        prod  = modv * KINV;
        xs    = IW'(prod >>> (DW - 1));
        fold  = (ang_e > HALF_A) || (ang_e < -HALF_A);
        v0.y  = '0;
        v0.x  = fold ? -xs : xs;
        if (!fold)
            v0.z = ang_e;
        else if (ang_e > 0)
            v0.z = ang_e - ONE_A;
        else
            v0.z = ang_e + ONE_A;
    end
endmodule

// File: rtl/cordic_stage.sv
module cordic_stage
    import cordic_pkg::*;
(
    input  vec_t            vi,
    input  logic [CNTW-1:0] idx,
    output vec_t            vo
);
    logic signed [IW-1:0] xi, yi, zi, xs, ys, at;

    always_comb begin
        xi = vi.x;
        yi = vi.y;
        zi = vi.z;
        xs = xi >>> idx;
        ys = yi >>> idx;
        at = {{GW{1'b0}}, atan_step(idx)};
        if (!zi[IW-1]) begin
            vo.x = xi - ys;
            vo.y = yi + xs;
            vo.z = zi - at;
        end else begin
            vo.x = xi + ys;
            vo.y = yi - xs;
            vo.z = zi + at;
        end
    end
endmodule

// File: rtl/cordic_post.sv
module cordic_post
    import cordic_pkg::*;
(
    input  vec_t          vf,
    input  func_e         fn,
    input  logic          narrow,
    output logic [DW-1:0] r1,
    output logic [DW-1:0] r2
);
    logic [DW-1:0] cpart, spart;

    always_comb begin
        cpart = fmt_out(vf.x, narrow);
        spart = fmt_out(vf.y, narrow);
        if (fn == FN_COS) begin
            r1 = cpart;
            r2 = spart;
        end else begin
            r1 = spart;
            r2 = cpart;
        end
    end
endmodule

// File: rtl/cordic_sincos.sv
module cordic_sincos
    import cordic_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          func_i,
    input  logic [3:0]    prec_i,
    input  logic          wide_i,
    input  logic [31:0]   arg1_i,
    input  logic [31:0]   arg2_i,
    output logic          done_o,
    output logic [31:0]   res1_o,
    output logic [31:0]   res2_o
);
    state_e          state_q;
    vec_t            vec_q, v_init, v_next;
    logic [CNTW-1:0] iter_q, last_q;
    func_e           fn_q;
    logic            wide_q;
    logic            done_q;
    logic [DW-1:0]   res1_q, res2_q, r1_c, r2_c;

    cordic_prep u_prep (
        .narrow (wide_i),
        .ang_in (arg1_i),
        .mod_in (arg2_i),
        .v0     (v_init)
    );

    cordic_stage u_stage (
        .vi  (vec_q),
        .idx (iter_q),
        .vo  (v_next)
    );

    cordic_post u_post (
        .vf     (vec_q),
        .fn     (fn_q),
        .narrow (wide_q),
        .r1     (r1_c),
        .r2     (r2_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            vec_q   <= '0;
            iter_q  <= '0;
            last_q  <= '0;
            fn_q    <= FN_COS;
            wide_q  <= 1'b0;
            done_q  <= 1'b0;
            res1_q  <= '0;
            res2_q  <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        vec_q   <= v_init;
                        iter_q  <= '0;
                        last_q  <= iter_total(prec_i) - CNTW'(1);
                        fn_q    <= func_e'(func_i);
                        wide_q  <= wide_i;
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    vec_q  <= v_next;
                    iter_q <= iter_q + CNTW'(1);
                    if (iter_q == last_q) state_q <= ST_FIN;
                end
                ST_FIN: begin
                    res1_q  <= r1_c;
                    res2_q  <= r2_c;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done_o = done_q;
    assign res1_o = res1_q;
    assign res2_o = res2_q;
endmodule

// File: rtl/cordic_sincos_chk.sv
module cordic_sincos_chk (
    input logic        clk,
    input logic        rst,
    input logic        start_i,
    input logic [3:0]  prec_i,
    input logic        done_o,
    input logic [31:0] res1_o,
    input logic [31:0] res2_o,
    input logic        busy,
    input logic        wide_q
);
    logic [5:0] cnt, expn;
    logic       track;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            expn  <= '0;
            track <= 1'b0;
        end else if (start_i && !busy) begin
            track <= 1'b1;
            cnt   <= '0;
            if (prec_i == 4'd0)      expn <= 6'd4;
            else if (prec_i > 4'd6)  expn <= 6'd24;
            else                     expn <= {prec_i, 2'b00};
        end else if (done_o) begin
            track <= 1'b0;
        end else if (track) begin
            cnt <= cnt + 6'd1;
        end
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (track && cnt == expn + 6'd1));

    assert_single_done_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(res1_o) && $stable(res2_o)));

    assert_narrow_range_R6: assert property (@(posedge clk) disable iff (rst)
        (done_o && wide_q) |-> ((res1_o[31:15] == 17'h0 || res1_o[31:15] == 17'h1FFFF) &&
                                (res2_o[31:15] == 17'h0 || res2_o[31:15] == 17'h1FFFF)));

    assert_reset_R11: assert property (@(posedge clk)
        rst |=> (!done_o && res1_o == 32'h0 && res2_o == 32'h0));
endmodule

bind cordic_sincos cordic_sincos_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .prec_i  (prec_i),
    .done_o  (done_o),
    .res1_o  (res1_o),
    .res2_o  (res2_o),
    .busy    (state_q != cordic_pkg::ST_IDLE),
    .wide_q  (wide_q)
);

// File: tb/cordic_sincos_test.sv
`timescale 1ns/1ps
module cordic_sincos_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        func_i = 1'b0;
    logic [3:0]  prec_i = 4'd0;
    logic        wide_i = 1'b0;
    logic [31:0] arg1_i = '0;
    logic [31:0] arg2_i = '0;
    logic        done_o;
    logic [31:0] res1_o, res2_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    cordic_sincos uut (
        .clk(clk), .rst(rst), .start_i(start_i), .func_i(func_i), .prec_i(prec_i),
        .wide_i(wide_i), .arg1_i(arg1_i), .arg2_i(arg2_i),
        .done_o(done_o), .res1_o(res1_o), .res2_o(res2_o)
    );

    task automatic chk_int(input bit ok, input string req, input string what,
                           input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_real(input string req, input string what,
                            input real act, input real exp, input real tol);
        real d;
        d = act - exp;
        if (d < 0.0) d = -d;
        checks++;
        if (d > tol) begin
            failures++;
            $display("FAIL %s %s: actual=%f expected=%f", req, what, act, exp);
        end
    endtask

    function automatic int iters(input logic [3:0] p);
        if (p == 0) return 4;
        if (p > 6) return 24;
        return 4 * p;
    endfunction

    function automatic real to_real(input logic [31:0] v, input logic nar);
        if (nar) return $itor($signed(v[15:0])) / 32768.0;
        return $itor($signed(v)) / 2147483648.0;
    endfunction

    // called at a negative edge; returns at the negative edge where done is high
    task automatic run_op(input logic fn, input logic [3:0] p, input logic nar,
                          input logic [31:0] a1, input logic [31:0] a2, output int k);
        func_i = fn; prec_i = p; wide_i = nar; arg1_i = a1; arg2_i = a2;
        start_i = 1'b1;
        k = 0;
        while (1) begin
            @(posedge clk);
            k++;
            @(negedge clk);
            if (k == 1) start_i = 1'b0;
            if (done_o || k > 60) break;
        end
    endtask

    task automatic check_op(input string tag, input logic fn, input logic [3:0] p,
                            input logic nar, input logic [31:0] a1, input logic [31:0] a2,
                            input int k);
        real th, m, e1, e2, tol;
        int n;
        n   = iters(p);
        th  = to_real(a1, nar) * 3.141592653589793;
        m   = to_real(a2, nar);
        e1  = fn ? m * $sin(th) : m * $cos(th);
        e2  = fn ? m * $cos(th) : m * $sin(th);
        tol = 2.0 ** (1 - n) + (nar ? 2.0 / 32768.0 : 2.0 ** -20);
        chk_int(k == n + 2, "R2", {tag, " latency"}, k, n + 2);
        chk_real(tag, "res1", to_real(res1_o, nar), e1, tol);
        chk_real(tag, "res2", to_real(res2_o, nar), e2, tol);
        if (nar) begin
            chk_int(res1_o[31:16] == {16{res1_o[15]}} && res2_o[31:16] == {16{res2_o[15]}},
                    "R5", "upper half sign extension", res1_o, 0);
        end
    endtask

    task automatic do_op(input string tag, input logic fn, input logic [3:0] p,
                         input logic nar, input logic [31:0] a1, input logic [31:0] a2);
        int k;
        run_op(fn, p, nar, a1, a2, k);
        check_op(tag, fn, p, nar, a1, a2, k);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int k, ndone;
        logic [31:0] h1, h2;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_int(done_o == 0 && res1_o == 0 && res2_o == 0, "R11", "reset state", res1_o, 0);

        // directed cases; each back-to-back call also starts in the done cycle (R10)
        do_op("R1 R4 cos", 1'b0, 4'd6, 1'b0, 32'h0000_0000, 32'h4000_0000);
        do_op("R1 R4 sin", 1'b1, 4'd6, 1'b0, 32'h2000_0000, 32'h6000_0000);
        do_op("R3 prec0", 1'b0, 4'd0, 1'b0, 32'h1000_0000, 32'h5000_0000);
        do_op("R3 cap", 1'b1, 4'd15, 1'b0, 32'hE000_0000, 32'h7000_0000);
        do_op("R3 prec9", 1'b0, 4'd9, 1'b0, 32'h3000_0000, 32'h2000_0000);
        do_op("R7 +0.75", 1'b0, 4'd3, 1'b0, 32'h6000_0000, 32'h4000_0000);
        do_op("R7 -0.75", 1'b1, 4'd5, 1'b0, 32'hA000_0000, 32'h4000_0000);
        do_op("R7 -1.0", 1'b0, 4'd6, 1'b0, 32'h8000_0000, 32'h5000_0000);
        do_op("R7 +0.999", 1'b1, 4'd6, 1'b0, 32'h7FFF_FFFF, 32'h5000_0000);
        do_op("R4 fullscale", 1'b0, 4'd6, 1'b0, 32'h0000_0000, 32'h7FFF_FFFF);
        chk_int(res1_o[31] == 1'b0, "R4", "full-scale no wrap", res1_o, 32'h7FFF_FFFF);
        do_op("R5 sin -0.5", 1'b1, 4'd4, 1'b1, 32'hFFFF_C000, 32'h0000_4000);
        do_op("R6 sat", 1'b0, 4'd6, 1'b1, 32'h1234_0000, 32'hABCD_7FFF);
        chk_int(res1_o == 32'h0000_7FFF, "R6", "positive limit", res1_o, 32'h7FFF);

        // random operands
        for (int i = 0; i < 40; i++) begin
            logic        fn, nar;
            logic [3:0]  p;
            logic [31:0] a1, a2;
            fn  = 1'($urandom);
            nar = 1'($urandom);
            p   = 4'($urandom_range(3, 6));
            if (i % 8 == 7) p = 4'($urandom);
            a1  = $urandom;
            a2  = nar ? ($urandom & 32'h0000_7FFF) : ($urandom & 32'h7FFF_FFFF);
            do_op(nar ? "R1 R5 rand" : "R1 R4 rand", fn, p, nar, a1, a2);
        end

        // R8 single pulse and R10 hold
        h1 = res1_o; h2 = res2_o;
        ndone = 0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (done_o) ndone++;
        end
        chk_int(ndone == 0, "R8", "done width", ndone, 0);
        chk_int(res1_o == h1 && res2_o == h2, "R10", "results hold", res1_o, h1);

        // R9 start during busy
        func_i = 1'b0; prec_i = 4'd6; wide_i = 1'b0;
        arg1_i = 32'h1555_5555; arg2_i = 32'h6000_0000;
        start_i = 1'b1;
        k = 0;
        while (1) begin
            @(posedge clk);
            k++;
            @(negedge clk);
            if (k == 1) start_i = 1'b0;
            if (k == 5) begin
                start_i = 1'b1; func_i = 1'b1; prec_i = 4'd3;
                arg1_i = 32'hC000_0000; arg2_i = 32'h2000_0000;
            end
            if (k == 6) start_i = 1'b0;
            if (done_o || k > 60) break;
        end
        check_op("R9 busy start", 1'b0, 4'd6, 1'b0, 32'h1555_5555, 32'h6000_0000, k);
        ndone = 0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (done_o) ndone++;
        end
        chk_int(ndone == 0, "R9", "no extra done", ndone, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule